// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache

This block is a 2-way set-associative data cache placed between a processor load/store port and a next-level memory port. Each 32-bit byte address is divided into a tag, a set index and a block offset. Both ways of the indexed set are compared in parallel, and a hit returns or updates the word in the same cycle as the request.

On a miss the processor is held off. The cache picks a victim way, writes that line back if it is dirty, fetches the whole line and then completes the access. Two parameters choose the store policies. The first selects write-back or write-through for store hits. The second selects write-allocate or write-around for store misses.

The processor must hold `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady from the cycle it raises the request until the cycle `cpu_ready` is high. The memory side moves a whole line in one beat for fills and write-backs. It moves a single word for write-through and write-around stores. Every memory transfer completes on the cycle where `mem_valid` and `mem_ready` are both high.

Top module: `sa_cache`

## Requirements
- R1: After reset every line is invalid and clean. The LRU bits are zero, `mem_valid` is low, and `cpu_ready` is low while `cpu_req` is low.
- R2: With the default 1024 sets and 16-byte lines, the address splits as follows. Bits 3:0 are the line offset, bits 13:4 the set index and bits 31:14 the tag. Address bits 3:2 select word k of a line, and word k sits at line bits 32k+31:32k. Every line transfer on the memory port carries an address whose offset bits are zero.
- R3: An access hits when a way of the indexed set is valid and holds the address tag. For a load, or a store under write-back, a hit raises `cpu_ready` in the same cycle as the request and makes no memory transfer. A load returns the stored word.
- R4: A load miss stalls the processor and makes exactly one line read at the line address. The access completes in the cycle after the fill handshake and returns the correct word.
- R5: If the indexed set has an invalid way, the fill goes into that way and no valid line is displaced.
- R6: With both ways valid, the victim is the least recently used way. The set's LRU bit is updated on every hit and every fill so that it names the way not just used.
- R7: Under write-back, a store hit writes only the cache and marks the line dirty. The next level is left unchanged.
- R8: Under write-back, a miss whose victim is valid and dirty first writes the victim line to its own line address. The fill request follows in the next cycle.
- R9: Under write-through, a store hit updates the cache and also issues a single-word write carrying the processor's address and data. The access completes on that handshake.
- R10: Under write-allocate, a store miss fills the line and then performs the store into the cache.
- R11: Under write-around, a store miss issues a single-word write and completes on its handshake. It leaves the cache unchanged, so a later load of that address misses.
- R12: While `mem_valid` is high and `mem_ready` is low, the memory request keeps its address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with ready |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = line read |
| mem_line | output | 1 | 1 = full-line transfer, 0 = single word |
| mem_addr | output | 32 | Memory byte address |
| mem_wline | output | LINE_W (128) | Line data for write-back |
| mem_wword | output | 32 | Word data for word writes |
| mem_ready | input | 1 | Memory accepts or answers the request |
| mem_rline | input | LINE_W (128) | Fill data, valid with ready |

## Verification
The assertions check the following on every cycle:
- a single-word write always carries the pending store's own address and data;
- load completions never coincide with memory traffic;
- a dirty write-back is followed at once by the fill;
- a load completes right after its fill;
- a stalled memory request stays stable.

Only the bench scenarios can show the remaining behaviours:
- the replacement order across a set, which way is filled first, and whether dirty data reaches memory on eviction;
- that write-around leaves the cache untouched;
- that stored data is returned on later loads.

Two cache instances with opposite policies run against bench memory models with random response delays.

// File: rtl/sa_cache.sv
module sa_cache #(
  parameter int SETS        = 1024,
  parameter int LINE_BYTES  = 16,
  parameter int WRITE_BACK  = 1,
  parameter int WRITE_ALLOC = 1,
  localparam int LINE_W     = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [31:0]       cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_write,
  output logic              mem_line,
  output logic [31:0]       mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  output logic [31:0]       mem_wword,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rline
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = 32 - OFF_W - IDX_W;
  localparam int WSEL_W = OFF_W - 2;
  localparam bit WB     = (WRITE_BACK != 0);
  localparam bit WA     = (WRITE_ALLOC != 0);

  typedef enum logic [1:0] {S_IDLE, S_WBK, S_FILL} state_t;

  state_t            state;
  logic [TAG_W-1:0]  tag_a [2][SETS];
  logic [LINE_W-1:0] dat_a [2][SETS];
  logic [SETS-1:0]   vld [2];
  logic [SETS-1:0]   drt [2];
  logic [SETS-1:0]   lru;
  logic              vic_q;

  wire [IDX_W-1:0]  idx  = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tag  = cpu_addr[31 -: TAG_W];
  wire [WSEL_W-1:0] wsel = cpu_addr[2 +: WSEL_W];

  wire hit0 = vld[0][idx] && (tag_a[0][idx] == tag);
  wire hit1 = vld[1][idx] && (tag_a[1][idx] == tag);
  wire hit  = hit0 | hit1;
  wire hway = hit1;
  wire idle = (state == S_IDLE);

  wire [LINE_W-1:0] hline = hway ? dat_a[1][idx] : dat_a[0][idx];
  assign cpu_rdata = hline[32*wsel +: 32];

  wire word_wr   = cpu_req && idle && cpu_we && (hit ? !WB : !WA);
  wire miss_go   = cpu_req && idle && !hit && !(cpu_we && !WA);
  wire vic_n     = !vld[0][idx] ? 1'b0 : (!vld[1][idx] ? 1'b1 : lru[idx]);
  wire vic_dirty = WB && vld[vic_n][idx] && drt[vic_n][idx];
  wire fill_done = (state == S_FILL) && mem_ready;

  assign cpu_ready = cpu_req && idle && (word_wr ? mem_ready : hit);
  wire   hit_done  = cpu_ready && hit;

  assign mem_valid = word_wr || (state == S_WBK) || (state == S_FILL);
  assign mem_write = word_wr || (state == S_WBK);
  assign mem_line  = !word_wr;
  assign mem_addr  = word_wr          ? cpu_addr :
                     (state == S_WBK) ? {tag_a[vic_q][idx], idx, {OFF_W{1'b0}}} :
                                        {tag, idx, {OFF_W{1'b0}}};
  assign mem_wline = dat_a[vic_q][idx];
  assign mem_wword = cpu_wdata;

  function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] line,
                                                 input logic [WSEL_W-1:0] sel,
                                                 input logic [31:0] w);
    logic [LINE_W-1:0] r;
    r = line;
    r[32*sel +: 32] = w;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (hit_done && cpu_we)
      dat_a[hway][idx] <= put_word(hline, wsel, cpu_wdata);
    else if (fill_done) begin
      dat_a[vic_q][idx] <= mem_rline;
      tag_a[vic_q][idx] <= tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      vic_q  <= 1'b0;
      vld[0] <= '0;
      vld[1] <= '0;
      drt[0] <= '0;
      drt[1] <= '0;
      lru    <= '0;
    end else begin
      case (state)
        S_IDLE: if (miss_go) begin
          vic_q <= vic_n;
          state <= vic_dirty ? S_WBK : S_FILL;
        end
        S_WBK:  if (mem_ready) state <= S_FILL;
        S_FILL: if (mem_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (hit_done) begin
        lru[idx] <= ~hway;
        if (cpu_we && WB) drt[hway][idx] <= 1'b1;
      end
      if (fill_done) begin
        vld[vic_q][idx] <= 1'b1;
        drt[vic_q][idx] <= 1'b0;
        lru[idx]        <= ~vic_q;
      end
    end
  end
endmodule

// File: rtl/sa_cache_chk.sv
module sa_cache_chk #(
  parameter int WRITE_BACK = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic [31:0] cpu_addr,
  input logic [31:0] cpu_wdata,
  input logic        cpu_ready,
  input logic        mem_valid,
  input logic        mem_write,
  input logic        mem_line,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wword,
  input logic        mem_ready
);
  a_r1_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  a_r3_load_done_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_we) |-> !mem_valid);

  a_r4_load_done_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_write && !cpu_we) |=> cpu_ready);

  a_r8_fill_follows_wbk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_write && mem_line) |=> (mem_valid && !mem_write && mem_line));

  a_r8_wbk_only_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && mem_line) |-> (WRITE_BACK != 0));

  a_r9_word_write_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !mem_line) |->
      (cpu_req && cpu_we && mem_addr == cpu_addr && mem_wword == cpu_wdata));

  a_r12_request_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
endmodule

bind sa_cache sa_cache_chk #(.WRITE_BACK(WRITE_BACK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
  .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
  .mem_valid(mem_valid), .mem_write(mem_write), .mem_line(mem_line),
  .mem_addr(mem_addr), .mem_wword(mem_wword), .mem_ready(mem_ready)
);

// File: tb/sim_sa_cache.sv
module mem_model (
  input  logic         clk,
  input  logic         valid,
  input  logic         write,
  input  logic         line,
  input  logic [31:0]  addr,
  input  logic [127:0] wline,
  input  logic [31:0]  wword,
  output logic         ready,
  output logic [127:0] rline
);
  logic [31:0] mem [128];
  int n_lr = 0, n_lw = 0, n_ww = 0;
  logic [31:0] last_addr = '0;

  function automatic int mi(input logic [31:0] a);
    return int'({a[15:14], a[6:4], a[3:2]});
  endfunction

  initial begin
    ready = 1'b0;
    for (int i = 0; i < 128; i++) mem[i] = 32'h1000_0000 + i * 32'h0001_0101;
  end

  always_comb
    for (int k = 0; k < 4; k++) rline[32*k +: 32] = mem[(mi(addr) & ~3) + k];

  always @(posedge clk) begin
    if (valid && ready) begin
      last_addr <= addr;
      if (write && line) begin
        n_lw <= n_lw + 1;
        for (int k = 0; k < 4; k++) mem[(mi(addr) & ~3) + k] <= wline[32*k +: 32];
      end else if (write) begin
        n_ww <= n_ww + 1;
        mem[mi(addr)] <= wword;
      end else n_lr <= n_lr + 1;
      ready <= 1'b0;
    end else if (valid) ready <= ($urandom % 2) == 0;
    else ready <= 1'b0;
  end
endmodule

module sim_sa_cache;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        req [2], we [2], rdy [2];
  logic [31:0] addr [2], wdata [2], rdata [2];
  logic         mv [2], mw [2], ml [2], mr [2];
  logic [31:0]  ma [2], mww [2];
  logic [127:0] mwl [2], mrl [2];

  sa_cache u0 (.clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_we(we[0]),
    .cpu_addr(addr[0]), .cpu_wdata(wdata[0]), .cpu_rdata(rdata[0]), .cpu_ready(rdy[0]),
    .mem_valid(mv[0]), .mem_write(mw[0]), .mem_line(ml[0]), .mem_addr(ma[0]),
    .mem_wline(mwl[0]), .mem_wword(mww[0]), .mem_ready(mr[0]), .mem_rline(mrl[0]));
  sa_cache #(.WRITE_BACK(0), .WRITE_ALLOC(0)) u1 (.clk(clk), .rst_n(rst_n),
    .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]), .cpu_wdata(wdata[1]),
    .cpu_rdata(rdata[1]), .cpu_ready(rdy[1]), .mem_valid(mv[1]), .mem_write(mw[1]),
    .mem_line(ml[1]), .mem_addr(ma[1]), .mem_wline(mwl[1]), .mem_wword(mww[1]),
    .mem_ready(mr[1]), .mem_rline(mrl[1]));

  mem_model m0 (.clk(clk), .valid(mv[0]), .write(mw[0]), .line(ml[0]), .addr(ma[0]),
    .wline(mwl[0]), .wword(mww[0]), .ready(mr[0]), .rline(mrl[0]));
  mem_model m1 (.clk(clk), .valid(mv[1]), .write(mw[1]), .line(ml[1]), .addr(ma[1]),
    .wline(mwl[1]), .wword(mww[1]), .ready(mr[1]), .rline(mrl[1]));

  int checks = 0, errors = 0;
  logic [31:0] refm [2][128];

  function automatic logic [31:0] mk(input int t, input int s, input int w);
    return {16'h0, t[1:0], 7'b0, s[2:0], w[1:0], 2'b00};
  endfunction
  function automatic int mi(input logic [31:0] a);
    return int'({a[15:14], a[6:4], a[3:2]});
  endfunction
  function automatic int cnt(input int lane, input int kind);
    if (lane == 0) return kind == 0 ? m0.n_lr : kind == 1 ? m0.n_lw : m0.n_ww;
    return kind == 0 ? m1.n_lr : kind == 1 ? m1.n_lw : m1.n_ww;
  endfunction
  function automatic logic [31:0] mword(input int lane, input logic [31:0] a);
    return lane == 0 ? m0.mem[mi(a)] : m1.mem[mi(a)];
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic acc(input int lane, input logic w, input logic [31:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output int lat);
    @(negedge clk);
    req[lane] = 1'b1; we[lane] = w; addr[lane] = a; wdata[lane] = d;
    lat = 0;
    #1;
    while (!rdy[lane]) begin @(negedge clk); #1; lat++; end
    rd = rdata[lane];
    if (w) refm[lane][mi(a)] = d;
    @(posedge clk); #1;
    req[lane] = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    int lat, lr, lw, ww;
    void'($urandom(1234));
    for (int l = 0; l < 2; l++) begin
      req[l] = 0; we[l] = 0; addr[l] = 0; wdata[l] = 0;
      for (int i = 0; i < 128; i++) refm[l][i] = 32'h1000_0000 + i * 32'h0001_0101;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready idle", {31'b0, rdy[0]}, 0);
    chk("R1 mem idle", {31'b0, mv[0] | mv[1]}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 no traffic after reset", {31'b0, mv[0] | mv[1] | rdy[0] | rdy[1]}, 0);

    lr = cnt(0, 0);
    acc(0, 0, mk(0,1,2), 0, rd, lat);
    chk("R4 miss data", rd, refm[0][mi(mk(0,1,2))]);
    chk("R4 one line read", cnt(0,0) - lr, 1);
    chk("R4 stalled", {31'b0, lat > 0}, 1);
    chk("R2 line address offset zero", m0.last_addr, mk(0,1,0));
    acc(0, 0, mk(0,1,3), 0, rd, lat);
    chk("R3 hit data word3", rd, refm[0][mi(mk(0,1,3))]);
    chk("R3 hit latency", lat, 0);
    chk("R3 no traffic", cnt(0,0) - lr, 1);

    acc(0, 0, mk(1,1,0), 0, rd, lat);
    chk("R5 second tag fill", cnt(0,0) - lr, 2);
    acc(0, 0, mk(0,1,0), 0, rd, lat);
    chk("R5 first tag kept", lat, 0);
    acc(0, 0, mk(1,1,1), 0, rd, lat);
    chk("R5 second tag kept", lat, 0);
    chk("R2 word select", rd, refm[0][mi(mk(1,1,1))]);

    acc(0, 0, mk(0,1,1), 0, rd, lat);
    acc(0, 0, mk(2,1,0), 0, rd, lat);
    chk("R6 third tag miss", cnt(0,0) - lr, 3);
    acc(0, 0, mk(0,1,2), 0, rd, lat);
    chk("R6 recent way kept", lat, 0);
    lr = cnt(0,0);
    acc(0, 0, mk(1,1,0), 0, rd, lat);
    chk("R6 lru way evicted", cnt(0,0) - lr, 1);
    chk("R6 refetched data", rd, refm[0][mi(mk(1,1,0))]);

    lr = cnt(0,0); lw = cnt(0,1); ww = cnt(0,2);
    acc(0, 1, mk(1,1,3), 32'hCAFE_0001, rd, lat);
    chk("R7 store hit latency", lat, 0);
    chk("R7 no traffic", (cnt(0,0)-lr) + (cnt(0,1)-lw) + (cnt(0,2)-ww), 0);
    chk("R7 memory unchanged", mword(0, mk(1,1,3)), 32'h1000_0000 + mi(mk(1,1,3)) * 32'h0001_0101);
    acc(0, 0, mk(1,1,3), 0, rd, lat);
    chk("R7 readback", rd, 32'hCAFE_0001);
    acc(0, 0, mk(0,1,0), 0, rd, lat);
    acc(0, 0, mk(3,1,0), 0, rd, lat);
    chk("R8 dirty victim written", cnt(0,1) - lw, 1);
    chk("R8 victim data in memory", mword(0, mk(1,1,3)), 32'hCAFE_0001);
    chk("R8 refill after writeback", cnt(0,0) - lr, 1);

    lr = cnt(0,0); ww = cnt(0,2);
    acc(0, 1, mk(2,5,1), 32'hBEEF_0002, rd, lat);
    chk("R10 allocate fill", cnt(0,0) - lr, 1);
    chk("R10 no word write", cnt(0,2) - ww, 0);
    acc(0, 0, mk(2,5,1), 0, rd, lat);
    chk("R10 store landed in cache", rd, 32'hBEEF_0002);
    chk("R10 hit after allocate", lat, 0);

    acc(1, 0, mk(0,2,0), 0, rd, lat);
    ww = cnt(1,2);
    acc(1, 1, mk(0,2,1), 32'h5A5A_0003, rd, lat);
    chk("R9 word write issued", cnt(1,2) - ww, 1);
    chk("R9 memory updated", mword(1, mk(0,2,1)), 32'h5A5A_0003);
    acc(1, 0, mk(0,2,1), 0, rd, lat);
    chk("R9 cache updated", rd, 32'h5A5A_0003);
    chk("R9 read hit", lat, 0);

    lr = cnt(1,0); ww = cnt(1,2);
    acc(1, 1, mk(1,3,2), 32'h7777_0004, rd, lat);
    chk("R11 word write", cnt(1,2) - ww, 1);
    chk("R11 no fill", cnt(1,0) - lr, 0);
    chk("R11 memory updated", mword(1, mk(1,3,2)), 32'h7777_0004);
    acc(1, 0, mk(1,3,2), 0, rd, lat);
    chk("R11 cache untouched so load misses", cnt(1,0) - lr, 1);
    chk("R11 load data", rd, 32'h7777_0004);

    for (int n = 0; n < 600; n++) begin
      int l = n % 2;
      logic [31:0] a = mk($urandom % 4, $urandom % 8, $urandom % 4);
      logic w = ($urandom % 3) == 0;
      acc(l, w, a, $urandom, rd, lat);
      if (!w) chk(l == 0 ? "R2 random WB/WA" : "R2 random WT/WAR", rd, refm[l][mi(a)]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule